// File: doc/BRIEF.md
# Self-Timed Carry Completion Adder/Subtractor

This block adds or subtracts two unsigned words. It does not wait a fixed worst-case ripple time. Instead, it reports completion as soon as every bit position knows its carry. Each position holds a pair of carry rails: one means "carry is one" and the other means "carry is zero". Both rails start cleared, and a position counts as resolved once exactly one of its rails is set.

The self-timed behaviour is modelled on a clock. One clock tick stands for one pass through two-level logic, which costs 2d of delay. A carry therefore travels up by one position per tick. A caller pulses `start` with the operands and a subtract select. It then waits for `done` and reads the result along with the number of ticks the operation used. The multiplier that uses this block sizes it to the width of its partial products and uses `done` to begin its next cycle.

Top module: `cca_addsub`

## Requirements
- R1: After synchronous reset, `done` is 0, `ticks` is 0, `sum` is 0 and `carry_out` is 0.
- R2: On the clock edge that samples `start` high, the block latches `op_a`, `op_b` and `sub`, clears every carry rail and `done`, and sets `ticks` to 0.
- R3: With `sub` = 0, the block produces `sum` = (A+B) mod 2^W when `done` rises, and `carry_out` is bit W of A+B.
- R4: With `sub` = 1, the block inverts B and forces the carry into bit 0 to 1. It then produces `sum` = (A−B) mod 2^W, and `carry_out` is 1 exactly when A ≥ B.
- R5: The block computes a resolution time for each position i. A position where A[i] equals B'[i] (B' being B, inverted when subtracting) resolves at tick 1. Any other position resolves at tick 1 when i = 0, and otherwise one tick after position i−1. `done` rises at the tick where the last position resolves, which is tick T. `ticks` then reads T, and `done` is seen T clock edges after the start edge.
- R6: Operands in which every position generates or kills a carry finish with `ticks` = 1.
- R7: Operands in which every position propagates finish with `ticks` = W.
- R8: The block ignores changes to `op_a`, `op_b` and `sub` after the start edge. After completion, `done`, `sum`, `carry_out` and `ticks` hold until the next `start`.
- R9: A position never has both carry rails set, and a set rail stays set until the next `start`.
- R10: A `start` that arrives before completion abandons the running operation, and only the new operands decide the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge is one 2d logic step |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches an operation |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub | input | 1 | 1 selects A−B, 0 selects A+B |
| sum | output | WIDTH | Registered result, valid while done is high |
| carry_out | output | 1 | Carry out of the top bit (1 means no borrow in subtraction) |
| done | output | 1 | Completion flag: every position has one rail set |
| ticks | output | CNT_W | Number of 2d steps used by the current or last operation |

## Verification
The bench goes after the two extremes of the completion time.

- **All-propagate operands (R7).** These must take W ticks. A design that wrongly treats the carry into bit 0 as unresolved would take W+1 ticks. A design that skips the rail chain would finish too early.
- **All-generate and all-kill operands (R6).** These must finish in one tick. A design that waits out a fixed ripple delay fails here.
- **Subtraction of equal operands.** This stresses the forced carry-in: if it is missing or inverted, the bench sees a wrong zero result or a wrong borrow.
- **Operand changes and restarts mid-operation (R8, R10).** The bench changes the operands after the start edge and restarts in mid-flight. A design that reads live inputs, or that keeps stale rails across a restart, returns the wrong word or the wrong tick count.

// File: rtl/cca_pkg.sv
package cca_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cca_state_e;

  function automatic int cnt_width(input int width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/cca_rail_cell.sv
module cca_rail_cell (
  input  logic bit_a,
  input  logic bit_b,
  input  logic in_one,
  input  logic in_zero,
  input  logic cur_one,
  input  logic cur_zero,
  output logic nxt_one,
  output logic nxt_zero
);
  logic gen, kill, prop;

  always_comb begin
    gen      = bit_a & bit_b;
    kill     = ~bit_a & ~bit_b;
    prop     = bit_a ^ bit_b;
    nxt_one  = cur_one  | gen  | (prop & in_one);
    nxt_zero = cur_zero | kill | (prop & in_zero);
  end
endmodule

// File: rtl/cca_resolve_detect.sv
module cca_resolve_detect #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] rail_one,
  input  logic [WIDTH-1:0] rail_zero,
  output logic             all_resolved
);
  logic [WIDTH-1:0] pos_ok;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    assign pos_ok[i] = rail_one[i] ^ rail_zero[i];
  end

  assign all_resolved = &pos_ok;
endmodule

// File: rtl/cca_addsub.sv
module cca_addsub
  import cca_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = cca_pkg::cnt_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done,
  output logic [CNT_W-1:0] ticks
);
  localparam int EXT_W = WIDTH + 1;

  cca_state_e       state_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             cin_q;
  logic [WIDTH-1:0] r_one_q, r_zero_q;
  logic [WIDTH-1:0] r_one_d, r_zero_d;
  logic [WIDTH:0]   chain_one, chain_zero;
  logic [WIDTH-1:0] sum_d;
  logic             resolved_d;
  logic [WIDTH-1:0] sum_q;
  logic             cout_q, done_q;
  logic [CNT_W-1:0] ticks_q;

  assign chain_one[0]  = cin_q;
  assign chain_zero[0] = ~cin_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign chain_one[i+1]  = r_one_q[i];
    assign chain_zero[i+1] = r_zero_q[i];

    cca_rail_cell u_cell (
      .bit_a   (a_q[i]),
      .bit_b   (b_q[i]),
      .in_one  (chain_one[i]),
      .in_zero (chain_zero[i]),
      .cur_one (r_one_q[i]),
      .cur_zero(r_zero_q[i]),
      .nxt_one (r_one_d[i]),
      .nxt_zero(r_zero_d[i])
    );

    if (i == 0) begin : g_lsb
      assign sum_d[i] = a_q[i] ^ b_q[i] ^ cin_q;
    end else begin : g_upper
      assign sum_d[i] = a_q[i] ^ b_q[i] ^ r_one_d[i-1];
    end
  end

  cca_resolve_detect #(.WIDTH(WIDTH)) u_detect (
    .rail_one    (r_one_d),
    .rail_zero   (r_zero_d),
    .all_resolved(resolved_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      cin_q    <= 1'b0;
      r_one_q  <= '0;
      r_zero_q <= '0;
      sum_q    <= '0;
      cout_q   <= 1'b0;
      done_q   <= 1'b0;
      ticks_q  <= '0;
    end else if (start) begin
      state_q  <= ST_RUN;
      a_q      <= op_a;
      b_q      <= sub ? ~op_b : op_b;
      cin_q    <= sub;
      r_one_q  <= '0;
      r_zero_q <= '0;
      done_q   <= 1'b0;
      ticks_q  <= '0;
    end else if (state_q == ST_RUN) begin
      r_one_q  <= r_one_d;
      r_zero_q <= r_zero_d;
      ticks_q  <= ticks_q + CNT_W'(1);
      if (resolved_d) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        sum_q   <= sum_d;
        cout_q  <= r_one_d[WIDTH-1];
      end
    end
  end

  assign sum       = sum_q;
  assign carry_out = cout_q;
  assign done      = done_q;
  assign ticks     = ticks_q;

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (r_one_q & r_zero_q) == '0); // R9

  AST_RAILS_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !start) |=>
      ((r_one_q & $past(r_one_q)) == $past(r_one_q)) &&
      ((r_zero_q & $past(r_zero_q)) == $past(r_zero_q))); // R9

  AST_DONE_RESOLVED: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((r_one_q ^ r_zero_q) == {WIDTH{1'b1}})); // R5

  AST_TICKS_BOUND: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (ticks_q >= CNT_W'(1) && ticks_q <= CNT_W'(WIDTH))); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done_q && ticks_q == '0 && r_one_q == '0 && r_zero_q == '0)); // R2

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |->
      {cout_q, sum_q} == (EXT_W'(a_q) + EXT_W'(b_q) + EXT_W'(cin_q))); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(sum_q) && $stable(ticks_q))); // R8
endmodule

// File: tb/cca_addsub_tb_top.sv
module cca_addsub_tb_top;
  localparam int W        = 16;
  localparam int CW       = $clog2(W + 1);
  localparam time CLK_PER = 10ns;
  localparam int WD_CYC   = 150000;

  logic          clk = 1'b0;
  logic          rst, start, sub;
  logic [W-1:0]  op_a, op_b, sum;
  logic          carry_out, done;
  logic [CW-1:0] ticks;

  int checks = 0;
  int errors = 0;

  cca_addsub #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .sub(sub), .sum(sum), .carry_out(carry_out), .done(done), .ticks(ticks)
  );

  always #(CLK_PER / 2) clk = ~clk;

  function automatic int exp_ticks(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic s);
    logic [W-1:0] bb;
    int t, m;
    bb = s ? ~b : b;
    t = 0;
    m = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] != bb[i]) t = t + 1;
      else t = 1;
      if (t > m) m = t;
    end
    return m;
  endfunction

  function automatic logic [W:0] exp_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic s);
    logic [W:0] bb;
    bb = s ? {1'b0, ~b} : {1'b0, b};
    return {1'b0, a} + bb + {{W{1'b0}}, s};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                        input string req);
    int cyc;
    int et;
    logic [W:0] er;
    et = exp_ticks(a, b, s);
    er = exp_result(a, b, s);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble the inputs after the start edge
    op_a = ~a; op_b = a ^ b; sub = ~s;
    check("R2 done cleared", 64'(done), 64'd0);
    check("R2 ticks cleared", 64'(ticks), 64'd0);
    cyc = 0;
    while (!done && cyc < W + 4) begin
      @(negedge clk);
      cyc++;
    end
    check({req, " R5 cycles"}, 64'(cyc), 64'(et));
    check({req, " R5 ticks"}, 64'(ticks), 64'(et));
    check({req, s ? " R4 sum" : " R3 sum"}, 64'(sum), 64'(er[W-1:0]));
    check({req, s ? " R4 carry" : " R3 carry"}, 64'(carry_out), 64'(er[W]));
  endtask

  initial begin
    #(CLK_PER * WD_CYC);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ha, hb;
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; sub = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", 64'(done), 64'd0);
    check("R1 ticks", 64'(ticks), 64'd0);
    check("R1 sum", 64'(sum), 64'd0);
    check("R1 carry", 64'(carry_out), 64'd0);

    run_op(16'hFFFF, 16'hFFFF, 1'b0, "R6 all-gen");
    check("R6 ticks one", 64'(ticks), 64'd1);
    run_op(16'h0000, 16'hFFFF, 1'b1, "R6 all-kill sub");
    check("R6 sub ticks one", 64'(ticks), 64'd1);
    run_op(16'hAAAA, 16'h5555, 1'b0, "R7 all-prop");
    check("R7 ticks W", 64'(ticks), 64'(W));
    run_op(16'h4B7C, 16'h4B7C, 1'b1, "R7 equal sub");
    check("R7 sub ticks W", 64'(ticks), 64'(W));
    run_op(16'h04B7, 16'h06C0, 1'b0, "R3 mixed");
    run_op(16'h0001, 16'h0002, 1'b1, "R4 borrow");

    // R8: results hold with no start
    ha = sum;
    repeat (5) @(negedge clk);
    check("R8 done hold", 64'(done), 64'd1);
    check("R8 sum hold", 64'(sum), 64'(ha));

    // R10: restart mid-flight
    @(negedge clk);
    op_a = 16'hAAAA; op_b = 16'h5555; sub = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    run_op(16'h1234, 16'h0F0F, 1'b0, "R10 restart");

    for (int n = 0; n < 300; n++) begin
      ha = W'($urandom);
      hb = W'($urandom);
      run_op(ha, hb, n[0], n[0] ? "R4 rand" : "R3 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule